// File: doc/BRIEF.md
# Duplex Controller Switch-Over Arbiter

This block decides which of two identical controller copies, copy 0 and copy 1, drives a shared controlled function. It produces the bus select for that function and a one-hot grant. Each copy has its own watchdog. The copy keeps its watchdog alive with single-cycle kick pulses. While both copies keep kicking, the pair runs in duplex mode. If the copy in control goes silent for the watchdog period, control passes to the other copy on the next clock edge. A switch-over alarm is then raised, and the silent copy is held in restart while the pair runs in simplex mode.

The starting owner is picked by a coin toss. The coin is a free-running linear feedback shift register whose top bit is loaded into the select register while reset is held. The owner after reset therefore depends on when reset is released. Other faults raise their own flags:
- A silent standby copy in duplex raises a standby-fault alarm. Control stays where it is.
- A silent sole survivor in simplex raises a total-failure flag. So does a silent owner whose partner is already expired.

Software clears the two alarms with an acknowledge pulse. A repair pulse returns the pair from simplex to duplex.

Top module: `dsa_arbiter`

## Requirements
- R1: `grant` is always one-hot, and the copy named by `sel` is the one granted: `grant[0]` is high when `sel` is 0, and `grant[1]` is high when `sel` is 1.
- R2: Reset is synchronous and active low. While reset is held, `sel` takes the top bit of a free-running LFSR each cycle. Different reset lengths give both copies as the starting owner.
- R3: A copy's watchdog expires once `WDT_CYCLES` clock edges pass after its last kick edge with no further kick. Any kick restarts the count from zero. No switch-over happens earlier.
- R4: After reset, `duplex` is 1 and `restart`, `alarm_switch`, `alarm_standby` and `total_fail` are all 0.
- R5: In duplex, if the owner's watchdog expires while the standby's has not, then at edge `WDT_CYCLES`+1 after the owner's last kick all of the following happen:
  - `sel` flips to the other copy;
  - `duplex` falls to 0;
  - `alarm_switch` rises.
- R6: In simplex, the copy not selected has its `restart` bit high. Its kicks are ignored, and its watchdog is held at zero.
- R7: In duplex, expiry of the standby's watchdog sets `alarm_standby` and leaves `sel` and `duplex` unchanged.
- R8: In duplex, if the owner's watchdog expires while the standby's is also expired, `total_fail` is set and `sel` stays unchanged.
- R9: In simplex, expiry of the owner's watchdog sets `total_fail` and leaves `sel` unchanged. `total_fail` stays set until reset.
- R10: A `repair` pulse in simplex returns `duplex` to 1 and clears `restart` on the next edge. The repaired copy's watchdog then counts from zero. A `repair` pulse in duplex has no effect.
- R11: An `ack` pulse clears `alarm_switch` and `alarm_standby` on the next edge. An alarm event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kick | input | 2 | Watchdog refresh pulse, one bit per copy |
| ack | input | 1 | Alarm acknowledge pulse |
| repair | input | 1 | Failed copy restored, return to duplex |
| sel | output | 1 | Copy that drives the shared bus |
| grant | output | 2 | One-hot grant per copy |
| restart | output | 2 | Hold-in-restart per copy |
| duplex | output | 1 | High in duplex mode, low in simplex |
| alarm_switch | output | 1 | Switch-over has happened |
| alarm_standby | output | 1 | Standby copy stopped kicking |
| total_fail | output | 1 | No healthy copy remains in control |

## Verification
The hardest states to reach from the ports are the double faults, because they need exact edge alignment:
- both watchdogs expiring in the same cycle while in duplex;
- the sole survivor expiring in simplex while a repair is or is not pending.

Directed phases stop both kicks on the same edge, and starve the new owner right after a switch-over. Seeded random phases then mix healthy and starved kick streams with sparse `ack` and `repair` pulses, so these collisions also occur with other events in the same cycle. The starting owner cannot be predicted from the ports, so the bench varies the reset length until both coin outcomes have appeared. It then tracks whichever owner the coin produced.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

    typedef enum logic {
        MODE_DUPLEX  = 1'b0,
        MODE_SIMPLEX = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  sel;
        logic  alm_sw;
        logic  alm_sb;
        logic  dead;
    } arb_state_t;

endpackage

// File: rtl/dsa_coin_lfsr.sv
module dsa_coin_lfsr #(
    parameter int                   W    = 8,
    parameter logic [W-1:0]         TAPS = 8'hB8
) (
    input  logic clk,
    output logic coin
);
    logic [W-1:0] s_d, s_q;

    // XNOR feedback: all-zero is a legal state, all-ones is escaped.
    always_comb begin
        if (&s_q) begin
            s_d = '0;
        end else begin
            s_d = {s_q[W-2:0], ~^(s_q & TAPS)};
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign coin = s_q[W-1];

endmodule

// File: rtl/dsa_watchdog.sv
module dsa_watchdog #(
    parameter int LIMIT = 16,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic hold,
    output logic expired,
    output logic fire
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          seen;
    } wd_state_t;

    wd_state_t wd_d, wd_q;

    assign expired = (wd_q.cnt == CW'(LIMIT));
    assign fire    = expired && !wd_q.seen;

    always_comb begin
        wd_d      = wd_q;
        wd_d.seen = expired;
        if (hold || kick) begin
            wd_d.cnt = '0;
        end else if (!expired) begin
            wd_d.cnt = wd_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_q <= '0;
        end else begin
            wd_q <= wd_d;
        end
    end

endmodule

// File: rtl/dsa_mode_fsm.sv
module dsa_mode_fsm
    import dsa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       coin,
    input  logic [1:0] fire,
    input  logic [1:0] expired,
    input  logic       ack,
    input  logic       repair,
    output arb_state_t st
);
    arb_state_t st_d, st_q;
    logic       own, spare;

    always_comb begin
        st_d  = st_q;
        own   = st_q.sel;
        spare = ~st_q.sel;
        if (ack) begin
            st_d.alm_sw = 1'b0;
            st_d.alm_sb = 1'b0;
        end
        case (st_q.mode)
            MODE_DUPLEX: begin
                if (fire[own]) begin
                    if (expired[spare]) begin
                        st_d.dead = 1'b1;
                    end else begin
                        st_d.sel    = spare;
                        st_d.mode   = MODE_SIMPLEX;
                        st_d.alm_sw = 1'b1;
                    end
                end
                if (fire[spare]) begin
                    st_d.alm_sb = 1'b1;
                end
            end
            default: begin
                if (fire[own]) begin
                    st_d.dead = 1'b1;
                end
                if (repair) begin
                    st_d.mode = MODE_DUPLEX;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode   <= MODE_DUPLEX;
            st_q.sel    <= coin;
            st_q.alm_sw <= 1'b0;
            st_q.alm_sb <= 1'b0;
            st_q.dead   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

endmodule

// File: rtl/dsa_arbiter.sv
module dsa_arbiter
    import dsa_pkg::*;
#(
    parameter int           WDT_CYCLES = 16,
    parameter int           LFSR_W     = 8,
    parameter logic [7:0]   LFSR_TAPS  = 8'hB8,
    localparam int          NCOPY      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCOPY-1:0] kick,
    input  logic             ack,
    input  logic             repair,
    output logic             sel,
    output logic [NCOPY-1:0] grant,
    output logic [NCOPY-1:0] restart,
    output logic             duplex,
    output logic             alarm_switch,
    output logic             alarm_standby,
    output logic             total_fail
);
    logic             coin;
    logic [NCOPY-1:0] wd_fire;
    logic [NCOPY-1:0] wd_exp;
    logic [NCOPY-1:0] hold;
    arb_state_t       st;

    dsa_coin_lfsr #(
        .W    (LFSR_W),
        .TAPS (LFSR_W'(LFSR_TAPS))
    ) u_coin (
        .clk  (clk),
        .coin (coin)
    );

    for (genvar i = 0; i < NCOPY; i++) begin : g_copy
        assign hold[i]  = (st.mode == MODE_SIMPLEX) && (st.sel != 1'(i));
        assign grant[i] = (st.sel == 1'(i));

        dsa_watchdog #(
            .LIMIT (WDT_CYCLES)
        ) u_wd (
            .clk     (clk),
            .rst_n   (rst_n),
            .kick    (kick[i]),
            .hold    (hold[i]),
            .expired (wd_exp[i]),
            .fire    (wd_fire[i])
        );
    end

    dsa_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .coin    (coin),
        .fire    (wd_fire),
        .expired (wd_exp),
        .ack     (ack),
        .repair  (repair),
        .st      (st)
    );

    assign sel           = st.sel;
    assign restart       = hold;
    assign duplex        = (st.mode == MODE_DUPLEX);
    assign alarm_switch  = st.alm_sw;
    assign alarm_standby = st.alm_sb;
    assign total_fail    = st.dead;

endmodule

// File: rtl/dsa_arbiter_chk.sv
module dsa_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic [1:0] grant,
    input logic       duplex,
    input logic       alarm_switch,
    input logic       alarm_standby,
    input logic       total_fail,
    input logic       ack,
    input logic       repair,
    input logic [1:0] wd_fire,
    input logic [1:0] wd_exp
);
    p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) == 1);

    p_switch_on_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (duplex && wd_fire[sel] && !wd_exp[~sel])
        |=> (!duplex && alarm_switch && (sel != $past(sel))));

    p_sel_moves_only_on_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(sel)) |-> ($past(duplex) && !duplex && alarm_switch));

    p_standby_no_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (duplex && wd_fire[~sel] && !wd_fire[sel]) |=> ($stable(sel) && alarm_standby && duplex));

    p_double_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (duplex && wd_fire[sel] && wd_exp[~sel]) |=> (total_fail && $stable(sel)));

    p_dead_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(total_fail)) |-> total_fail);

    p_repair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!duplex && repair) |=> duplex);

    p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (wd_fire == 2'b00)) |=> (!alarm_switch && !alarm_standby));

endmodule

bind dsa_arbiter dsa_arbiter_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel           (sel),
    .grant         (grant),
    .duplex        (duplex),
    .alarm_switch  (alarm_switch),
    .alarm_standby (alarm_standby),
    .total_fail    (total_fail),
    .ack           (ack),
    .repair        (repair),
    .wd_fire       (wd_fire),
    .wd_exp        (wd_exp)
);

// File: tb/dsa_arbiter_tb_top.sv
module dsa_arbiter_tb_top;
    localparam int WDT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] kick = 2'b00;
    logic       ack = 1'b0;
    logic       repair = 1'b0;
    logic       sel, duplex, alarm_switch, alarm_standby, total_fail;
    logic [1:0] grant, restart;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    dsa_arbiter #(.WDT_CYCLES(WDT)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .kick          (kick),
        .ack           (ack),
        .repair        (repair),
        .sel           (sel),
        .grant         (grant),
        .restart       (restart),
        .duplex        (duplex),
        .alarm_switch  (alarm_switch),
        .alarm_standby (alarm_standby),
        .total_fail    (total_fail)
    );

    typedef struct packed {
        logic [7:0] c0;
        logic [7:0] c1;
        logic       s0;
        logic       s1;
        logic       simplex;
        logic       sel;
        logic       asw;
        logic       asb;
        logic       dead;
    } mdl_t;

    mdl_t m;

    function automatic mdl_t mdl_next(mdl_t c, logic [1:0] k, logic a, logic r);
        mdl_t n = c;
        logic [7:0] cnt [2];
        logic [1:0] ex, fi, hd;
        cnt[0] = c.c0;
        cnt[1] = c.c1;
        for (int i = 0; i < 2; i++) begin
            ex[i] = (cnt[i] == 8'(WDT));
            fi[i] = ex[i] && !(i == 0 ? c.s0 : c.s1);
            hd[i] = c.simplex && (c.sel != 1'(i));
        end
        n.c0 = (hd[0] || k[0]) ? 8'd0 : (ex[0] ? c.c0 : c.c0 + 8'd1);
        n.c1 = (hd[1] || k[1]) ? 8'd0 : (ex[1] ? c.c1 : c.c1 + 8'd1);
        n.s0 = ex[0];
        n.s1 = ex[1];
        if (a) begin
            n.asw = 1'b0;
            n.asb = 1'b0;
        end
        if (!c.simplex) begin
            if (fi[c.sel]) begin
                if (ex[~c.sel]) n.dead = 1'b1;
                else begin
                    n.sel = ~c.sel;
                    n.simplex = 1'b1;
                    n.asw = 1'b1;
                end
            end
            if (fi[~c.sel]) n.asb = 1'b1;
        end else begin
            if (fi[c.sel]) n.dead = 1'b1;
            if (r) n.simplex = 1'b0;
        end
        return n;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [1:0] eg, er;
        eg = m.sel ? 2'b10 : 2'b01;
        er = m.simplex ? (m.sel ? 2'b01 : 2'b10) : 2'b00;
        chk(grant == eg, "R1 grant", grant, eg);
        chk(sel == m.sel, "R5 sel", sel, m.sel);
        chk(duplex == !m.simplex, "R5 duplex", duplex, !m.simplex);
        chk(alarm_switch == m.asw, "R11 alarm_switch", alarm_switch, m.asw);
        chk(alarm_standby == m.asb, "R7 alarm_standby", alarm_standby, m.asb);
        chk(total_fail == m.dead, "R9 total_fail", total_fail, m.dead);
        chk(restart == er, "R6 restart", restart, er);
    endtask

    task automatic step(input logic [1:0] k, input logic a, input logic r);
        kick = k;
        ack = a;
        repair = r;
        @(posedge clk);
        m = mdl_next(m, k, a, r);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset(input int n);
        rst_n = 1'b0;
        kick = 2'b00;
        ack = 1'b0;
        repair = 1'b0;
        repeat (n) @(negedge clk);
        m = '0;
        m.sel = sel;
        chk(duplex == 1'b1, "R4 duplex after reset", duplex, 1);
        chk({restart, alarm_switch, alarm_standby, total_fail} == 5'b0, "R4 flags after reset",
            {restart, alarm_switch, alarm_standby, total_fail}, 0);
        chk(grant == (sel ? 2'b10 : 2'b01), "R1 grant after reset", grant, sel ? 2'b10 : 2'b01);
        rst_n = 1'b1;
    endtask

    function automatic logic [1:0] only(input logic c);
        return c ? 2'b10 : 2'b01;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic owner;
        bit seen0, seen1;
        void'($urandom(32'd24681));
        @(negedge clk);

        // R2: coin toss over several reset lengths
        seen0 = 0;
        seen1 = 0;
        for (int i = 1; i <= 16; i++) begin
            do_reset(i);
            if (sel) seen1 = 1; else seen0 = 1;
            for (int j = 0; j < i + 3; j++) step(2'b11, 0, 0);
        end
        chk(seen0 && seen1, "R2 both coin outcomes", {seen1, seen0}, 2'b11);

        // R3 / R5: owner goes silent, standby healthy
        do_reset(3);
        for (int j = 0; j < 4; j++) step(2'b11, 0, 0);
        owner = m.sel;
        for (int j = 0; j < WDT; j++) step(only(~owner), 0, 0);
        chk(duplex == 1'b1 && sel == owner, "R3 no switch before timeout", {duplex, sel}, {1'b1, owner});
        step(only(~owner), 0, 0);
        chk(sel == ~owner, "R5 sel flipped", sel, ~owner);
        chk(alarm_switch && !duplex, "R5 alarm and simplex", {alarm_switch, duplex}, 2'b10);

        // R6: kicks from the held copy are ignored
        for (int j = 0; j < 2 * WDT; j++) step(2'b11, 0, 0);
        chk(restart == only(owner) && !duplex, "R6 failed copy held", restart, only(owner));

        // R11: acknowledge
        step(only(~owner), 1, 0);
        chk(!alarm_switch, "R11 ack clears", alarm_switch, 0);

        // R10: repair, then repaired copy watchdog from zero
        step(2'b00, 0, 1);
        chk(duplex && restart == 2'b00, "R10 back to duplex", {duplex, restart}, 3'b100);
        for (int j = 0; j < WDT + 1; j++) step(only(~owner), 0, 0);
        chk(alarm_standby && duplex && sel == ~owner, "R7 standby expiry", {alarm_standby, duplex}, 2'b11);
        step(2'b11, 0, 1);
        chk(duplex && sel == ~owner, "R10 repair in duplex ignored", {duplex, sel}, {1'b1, ~owner});

        // R9: switch then starve survivor
        owner = m.sel;
        for (int j = 0; j < WDT + 1; j++) step(only(~owner), 0, 0);
        chk(!duplex, "R5 second switch", duplex, 0);
        for (int j = 0; j < WDT + 1; j++) step(2'b00, 0, 0);
        chk(total_fail && sel == ~owner, "R9 survivor expiry", {total_fail, sel}, {1'b1, ~owner});
        for (int j = 0; j < 5; j++) step(2'b11, 1, 1);
        chk(total_fail, "R9 total_fail sticky", total_fail, 1);

        // R8: both expire together in duplex
        do_reset(2);
        for (int j = 0; j < 3; j++) step(2'b11, 0, 0);
        owner = m.sel;
        for (int j = 0; j < WDT + 1; j++) step(2'b00, 0, 0);
        chk(total_fail && sel == owner && duplex, "R8 double fault", {total_fail, sel, duplex}, {1'b1, owner, 1'b1});

        // Random phases
        for (int rnd = 0; rnd < 30; rnd++) begin
            do_reset(1 + ($urandom % 8));
            for (int seg = 0; seg < 10; seg++) begin
                int p0, p1;
                p0 = ($urandom % 3 == 0) ? 0 : 1 + ($urandom % 4);
                p1 = ($urandom % 3 == 0) ? 0 : 1 + ($urandom % 4);
                for (int j = 0; j < 50; j++) begin
                    logic [1:0] k;
                    k[0] = (p0 != 0) && ($urandom % p0 == 0);
                    k[1] = (p1 != 0) && ($urandom % p1 == 0);
                    step(k, ($urandom % 20) == 0, ($urandom % 40) == 0);
                end
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule